// File: doc/BRIEF.md
# Tile Line-Scan Defect Detector

This block inspects one scan line of a tile moving under a line-scan camera. A part-present trigger arms it. It then stores the next line of 8-bit grey pixels in an internal line memory. Only cycles with the pixel valid strobe high are stored, so the camera may leave gaps in the stream. Once the line is complete, the block reads the line back one pixel per cycle. Each pixel brighter than a background threshold counts as tile surface.

A tile pixel fails the surface check if it is darker than a dark threshold or brighter than a light threshold. The tile's extent is taken from the first and last pixels above the background threshold. That extent must lie within a programmed width window. Both results are combined into one accept/reject verdict, which is published with a single-cycle done pulse.

Triggers that arrive while an inspection is running are dropped. Each dropped trigger is tallied in a saturating overrun counter. The threshold inputs must be held steady from the arming trigger until the done pulse.

Top module: `tile_inspector`

## Requirements
- R1: After reset, doneOut, surfDefect, edgeDefect and rejectOut are 0 and overrunCount is 0.
- R2: Capture starts only when trigIn is high in a cycle where the block is idle. Pixels presented while idle are not stored and have no effect on any verdict.
- R3: A line is LINE_LEN (default 1024) pixels of PIX_W (8) bits. Only cycles with pixValid high are stored, at consecutive positions starting at 0.
- R4: The surface defect is set when any line pixel with value strictly above bgThr is strictly below darkThr or strictly above lightThr. A value equal to either threshold passes.
- R5: The tile's left edge is the lowest position whose value is strictly above bgThr, and its right edge is the highest such position. Its width is right − left + 1. The edge defect is set when no pixel exceeds bgThr, or when the width is below minWidth or above maxWidth. A width equal to either limit passes.
- R6: rejectOut equals surfDefect OR edgeDefect for every inspected tile.
- R7: doneOut is high for exactly one cycle, LINE_LEN+2 clock edges after the edge that stores the last pixel. surfDefect, edgeDefect and rejectOut change only together with that pulse and hold until the next one.
- R8: A trigIn sampled high while the block is not idle is ignored and adds 1 to overrunCount, which saturates at 2^CNT_W − 1. This includes the reporting cycle just before doneOut. The capture in progress is unaffected.
- R9: The block is idle again in the cycle doneOut is high, so a trigger sampled in that cycle starts a new capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| trigIn | input | 1 | Tile-present trigger, sampled per cycle |
| pixValid | input | 1 | Pixel strobe |
| pixData | input | PIX_W | Grey pixel value |
| darkThr | input | PIX_W | Lowest acceptable surface value |
| lightThr | input | PIX_W | Highest acceptable surface value |
| bgThr | input | PIX_W | Values above this are tile, others background |
| minWidth | input | IDX_W+1 | Minimum tile width in pixels |
| maxWidth | input | IDX_W+1 | Maximum tile width in pixels |
| doneOut | output | 1 | One-cycle result strobe |
| surfDefect | output | 1 | Surface intensity defect of last tile |
| edgeDefect | output | 1 | Edge or width defect of last tile |
| rejectOut | output | 1 | Reject verdict of last tile |
| overrunCount | output | CNT_W | Saturating count of dropped triggers |

## Verification
Two events can share a cycle. A trigger can land on the reporting cycle, one edge before doneOut rises. A trigger can also land on the cycle in which doneOut is high. The bench counts LINE_LEN+2 edges from the last stored pixel to place a trigger on each of these cycles. The first must raise overrunCount by one and leave the verdict untouched. The second must start a fresh capture, which the bench then completes and judges against its own model.

// File: rtl/tile_insp_pkg.sv
package tile_insp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAPTURE,
    ST_ANALYSE,
    ST_DRAIN,
    ST_REPORT
  } inspState_t;

  typedef struct packed {
    logic capClear;
    logic capWrite;
    logic anaRead;
    logic report;
  } ctrlStrobe_t;

endpackage

// File: rtl/tile_insp_ctrl.sv
module tile_insp_ctrl
  import tile_insp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trigIn,
  input  logic             pixValid,
  input  logic             capLast,
  input  logic             rdLast,
  output ctrlStrobe_t      strobe,
  output logic [CNT_W-1:0] overrunCount
);

  localparam logic [CNT_W-1:0] OVR_MAX = {CNT_W{1'b1}};

  inspState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:    if (trigIn) stateNext = ST_CAPTURE;
      ST_CAPTURE: if (pixValid && capLast) stateNext = ST_ANALYSE;
      ST_ANALYSE: if (rdLast) stateNext = ST_DRAIN;
      ST_DRAIN:   stateNext = ST_REPORT;
      ST_REPORT:  stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.capClear = (state == ST_IDLE) && trigIn;
    strobe.capWrite = (state == ST_CAPTURE) && pixValid;
    strobe.anaRead  = (state == ST_ANALYSE);
    strobe.report   = (state == ST_REPORT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      overrunCount <= '0;
    else if (trigIn && (state != ST_IDLE) && (overrunCount != OVR_MAX))
      overrunCount <= overrunCount + 1'b1;
  end

  // R2: an idle trigger always arms capture
  assert_arm_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && trigIn) |=> (state == ST_CAPTURE));

  // R8: busy trigger raises the overrun tally by one below saturation
  assert_overrun_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trigIn && state != ST_IDLE && overrunCount != OVR_MAX)
      |=> (overrunCount == CNT_W'($past(overrunCount) + 1'b1)));

  // R8: the tally never moves while idle
  assert_overrun_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |=> $stable(overrunCount));

endmodule

// File: rtl/tile_insp_datapath.sv
module tile_insp_datapath
  import tile_insp_pkg::*;
#(
  parameter int LINE_LEN = 1024,
  parameter int PIX_W    = 8,
  localparam int IDX_W   = $clog2(LINE_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobe_t      strobe,
  input  logic [PIX_W-1:0] pixData,
  input  logic [PIX_W-1:0] darkThr,
  input  logic [PIX_W-1:0] lightThr,
  input  logic [PIX_W-1:0] bgThr,
  input  logic [IDX_W:0]   minWidth,
  input  logic [IDX_W:0]   maxWidth,
  output logic             capLast,
  output logic             rdLast,
  output logic             doneOut,
  output logic             surfDefect,
  output logic             edgeDefect,
  output logic             rejectOut
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINE_LEN - 1);

  logic [PIX_W-1:0] lineMem [LINE_LEN];
  logic [IDX_W-1:0] wrPtr, rdPtr, evalIdx;
  logic [PIX_W-1:0] rdData;
  logic             evalValid;
  logic             surfAcc, tileFound;
  logic [IDX_W-1:0] leftPos, rightPos;
  logic [IDX_W:0]   tileWidth;
  logic             edgeBad;

  assign capLast = (wrPtr == LAST_IDX);
  assign rdLast  = (rdPtr == LAST_IDX);

  always_ff @(posedge clk) begin
    if (strobe.capWrite) lineMem[wrPtr] <= pixData;
    rdData <= lineMem[rdPtr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      evalIdx   <= '0;
      evalValid <= 1'b0;
    end else begin
      if (strobe.capClear)      wrPtr <= '0;
      else if (strobe.capWrite) wrPtr <= wrPtr + 1'b1;
      if (strobe.capClear)      rdPtr <= '0;
      else if (strobe.anaRead)  rdPtr <= rdPtr + 1'b1;
      evalValid <= strobe.anaRead;
      evalIdx   <= rdPtr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      surfAcc   <= 1'b0;
      tileFound <= 1'b0;
      leftPos   <= '0;
      rightPos  <= '0;
    end else if (strobe.capClear) begin
      surfAcc   <= 1'b0;
      tileFound <= 1'b0;
      leftPos   <= '0;
      rightPos  <= '0;
    end else if (evalValid && (rdData > bgThr)) begin
      if ((rdData < darkThr) || (rdData > lightThr)) surfAcc <= 1'b1;
      if (!tileFound) leftPos <= evalIdx;
      tileFound <= 1'b1;
      rightPos  <= evalIdx;
    end
  end

  assign tileWidth = {1'b0, rightPos} - {1'b0, leftPos} + 1'b1;
  assign edgeBad   = !tileFound || (tileWidth < minWidth) || (tileWidth > maxWidth);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      doneOut    <= 1'b0;
      surfDefect <= 1'b0;
      edgeDefect <= 1'b0;
      rejectOut  <= 1'b0;
    end else begin
      doneOut <= strobe.report;
      if (strobe.report) begin
        surfDefect <= surfAcc;
        edgeDefect <= edgeBad;
        rejectOut  <= surfAcc || edgeBad;
      end
    end
  end

  // R7: the reporting cycle is followed by the done strobe
  assert_report_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.report |=> doneOut);

  // R7: done never lasts two cycles
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    doneOut |=> !doneOut);

  // R7: verdict outputs only move with the done strobe
  assert_verdict_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.report |=> ($stable(surfDefect) && $stable(edgeDefect) && $stable(rejectOut)));

  // R3: the write pointer moves only on stored pixels or rearm
  assert_wrptr_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.capWrite && !strobe.capClear) |=> $stable(wrPtr));

endmodule

// File: rtl/tile_inspector.sv
module tile_inspector
  import tile_insp_pkg::*;
#(
  parameter int LINE_LEN = 1024,
  parameter int PIX_W    = 8,
  parameter int CNT_W    = 8,
  localparam int IDX_W   = $clog2(LINE_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trigIn,
  input  logic             pixValid,
  input  logic [PIX_W-1:0] pixData,
  input  logic [PIX_W-1:0] darkThr,
  input  logic [PIX_W-1:0] lightThr,
  input  logic [PIX_W-1:0] bgThr,
  input  logic [IDX_W:0]   minWidth,
  input  logic [IDX_W:0]   maxWidth,
  output logic             doneOut,
  output logic             surfDefect,
  output logic             edgeDefect,
  output logic             rejectOut,
  output logic [CNT_W-1:0] overrunCount
);

  ctrlStrobe_t strobe;
  logic        capLast, rdLast;

  tile_insp_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .trigIn       (trigIn),
    .pixValid     (pixValid),
    .capLast      (capLast),
    .rdLast       (rdLast),
    .strobe       (strobe),
    .overrunCount (overrunCount)
  );

  tile_insp_datapath #(.LINE_LEN(LINE_LEN), .PIX_W(PIX_W)) uData (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .pixData    (pixData),
    .darkThr    (darkThr),
    .lightThr   (lightThr),
    .bgThr      (bgThr),
    .minWidth   (minWidth),
    .maxWidth   (maxWidth),
    .capLast    (capLast),
    .rdLast     (rdLast),
    .doneOut    (doneOut),
    .surfDefect (surfDefect),
    .edgeDefect (edgeDefect),
    .rejectOut  (rejectOut)
  );

endmodule

// File: tb/tb_tile_inspector.sv
module tb_tile_inspector;

  localparam int CLK_PERIOD = 10;
  localparam int LINE_LEN   = 1024;
  localparam int PIX_W      = 8;
  localparam int CNT_W      = 8;
  localparam int IDX_W      = $clog2(LINE_LEN);
  localparam int OVR_MAX    = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             trigIn = 1'b0;
  logic             pixValid = 1'b0;
  logic [PIX_W-1:0] pixData = '0;
  logic [PIX_W-1:0] darkThr = 8'd100;
  logic [PIX_W-1:0] lightThr = 8'd220;
  logic [PIX_W-1:0] bgThr = 8'd40;
  logic [IDX_W:0]   minWidth = 11'd600;
  logic [IDX_W:0]   maxWidth = 11'd800;
  logic             doneOut, surfDefect, edgeDefect, rejectOut;
  logic [CNT_W-1:0] overrunCount;

  int compared = 0;
  int mismatched = 0;
  int expOvr = 0;
  logic [PIX_W-1:0] line [LINE_LEN];

  always #(CLK_PERIOD/2) clk = ~clk;

  tile_inspector #(.LINE_LEN(LINE_LEN), .PIX_W(PIX_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .trigIn(trigIn), .pixValid(pixValid), .pixData(pixData),
    .darkThr(darkThr), .lightThr(lightThr), .bgThr(bgThr),
    .minWidth(minWidth), .maxWidth(maxWidth),
    .doneOut(doneOut), .surfDefect(surfDefect), .edgeDefect(edgeDefect),
    .rejectOut(rejectOut), .overrunCount(overrunCount)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit modelSurf();
    bit bad = 0;
    for (int k = 0; k < LINE_LEN; k++)
      if (line[k] > bgThr && (line[k] < darkThr || line[k] > lightThr)) bad = 1;
    return bad;
  endfunction

  function automatic bit modelEdge();
    int left = -1;
    int right = -1;
    int w;
    for (int k = 0; k < LINE_LEN; k++)
      if (line[k] > bgThr) begin
        if (left < 0) left = k;
        right = k;
      end
    if (left < 0) return 1;
    w = right - left + 1;
    return (w < int'(minWidth)) || (w > int'(maxWidth));
  endfunction

  function automatic void fillTile(int a, int b, int val);
    for (int k = 0; k < LINE_LEN; k++)
      line[k] = (k >= a && k <= b) ? PIX_W'(val) : 8'd10;
  endfunction

  function automatic void bumpOvr();
    if (expOvr < OVR_MAX) expOvr++;
  endfunction

  task automatic runTile(input string tag, input int gapPct, input bit trigBusy,
                         input bit armed, input bit trigAtReport, input bit trigAtDone);
    bit eSurf, eEdge;
    eSurf = modelSurf();
    eEdge = modelEdge();
    if (!armed) begin
      @(negedge clk); trigIn = 1'b1; pixValid = 1'b0;
    end
    for (int k = 0; k < LINE_LEN; k++) begin
      while (($urandom % 100) < gapPct) begin
        @(negedge clk); pixValid = 1'b0; pixData = 8'($urandom);
        trigIn = trigBusy; if (trigBusy) bumpOvr();
      end
      @(negedge clk); pixValid = 1'b1; pixData = line[k];
      trigIn = trigBusy && k[0]; if (trigBusy && k[0]) bumpOvr();
    end
    for (int i = 0; i <= LINE_LEN; i++) begin
      @(negedge clk); pixValid = 1'b0; trigIn = 1'b0;
      if (i == 0) check({tag, " R7 no early done"}, doneOut, 0);
    end
    @(negedge clk); trigIn = trigAtReport; if (trigAtReport) bumpOvr();
    check({tag, " R7 done not before report"}, doneOut, 0);
    @(negedge clk); trigIn = trigAtDone;
    check({tag, " R7 done pulse"}, doneOut, 1);
    check({tag, " R4 surface"}, surfDefect, eSurf);
    check({tag, " R5 edge"}, edgeDefect, eEdge);
    check({tag, " R6 reject"}, rejectOut, eSurf | eEdge);
    check({tag, " R8 overrun"}, overrunCount, expOvr);
    @(negedge clk); trigIn = 1'b0;
    check({tag, " R7 done one cycle"}, doneOut, 0);
    check({tag, " R7 verdict held"}, rejectOut, eSurf | eEdge);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 done", doneOut, 0);
    check("R1 surf", surfDefect, 0);
    check("R1 edge", edgeDefect, 0);
    check("R1 reject", rejectOut, 0);
    check("R1 overrun", overrunCount, 0);
    rst_n = 1'b1;

    // R2: bright pixels while idle must not land in memory
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); pixValid = 1'b1; pixData = 8'd255;
    end
    @(negedge clk); pixValid = 1'b0;
    check("R2 idle stream no done", doneOut, 0);
    fillTile(200, 899, 150);
    runTile("clean R2 R3", 0, 0, 0, 0, 0);

    // R4 boundaries: values equal to thresholds pass, one beyond fails
    fillTile(200, 899, 150); line[300] = 8'd100; line[301] = 8'd220;
    runTile("R4 equal", 10, 0, 0, 0, 0);
    fillTile(200, 899, 150); line[500] = 8'd99;
    runTile("R4 dark", 10, 0, 0, 0, 0);
    fillTile(200, 899, 150); line[899] = 8'd221;
    runTile("R4 light", 10, 0, 0, 0, 0);

    // R5 width limits
    fillTile(100, 699, 150); runTile("R5 min", 0, 0, 0, 0, 0);
    fillTile(100, 899, 150); runTile("R5 max", 0, 0, 0, 0, 0);
    fillTile(100, 698, 150); runTile("R5 narrow", 0, 0, 0, 0, 0);
    fillTile(100, 900, 150); runTile("R5 wide", 0, 0, 0, 0, 0);
    fillTile(0, -1, 150);    runTile("R5 no tile", 0, 0, 0, 0, 0);
    fillTile(0, 1023, 150); minWidth = 11'd1024; maxWidth = 11'd1024;
    runTile("R5 full line", 0, 0, 0, 0, 0);
    minWidth = 11'd600; maxWidth = 11'd800;

    // R8 busy triggers, saturation, report-cycle trigger; R9 trigger with done
    fillTile(150, 850, 180); line[400] = 8'd60;
    runTile("R8 busy", 5, 1, 0, 1, 1);
    fillTile(120, 760, 170);
    runTile("R9 rearm at done", 0, 0, 1, 0, 0);
    check("R8 saturated", overrunCount, OVR_MAX);

    // randomized tiles
    for (int t = 0; t < 8; t++) begin
      int a, b;
      bgThr    = 8'(20 + $urandom % 40);
      darkThr  = 8'(90 + $urandom % 40);
      lightThr = 8'(190 + $urandom % 50);
      minWidth = 11'(500 + $urandom % 100);
      maxWidth = 11'(700 + $urandom % 150);
      a = $urandom % 200;
      b = a + 450 + $urandom % 400;
      if (b > LINE_LEN - 1) b = LINE_LEN - 1;
      for (int k = 0; k < LINE_LEN; k++)
        line[k] = (k >= a && k <= b) ? 8'(85 + $urandom % 160) : 8'($urandom % 30);
      if (t[0]) for (int k = a; k <= b; k++) line[k] = 8'(140 + $urandom % 40);
      runTile("rand R4 R5 R6", 15, 0, 0, 0, 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule